// File: doc/BRIEF.md
# Power Mode and Reset Controller

This block decides when the clocks of a small 8-bit microcontroller core run, and when its internal reset is asserted. It runs from the oscillator clock. It counts oscillator periods into machine cycles and qualifies the external reset pin against whole machine cycles. It steps through four operating states: run, idle, power-down, and a short wake window that opens when a reset pin edge ends idle.

Software raises single-cycle pulses to request idle or power-down.
- **Idle** stops only the CPU clock. Any pending enabled interrupt ends it.
- **Power-down** also stops the oscillator. Only a qualified reset ends it.
- **Reset during idle:** when the reset pin ends idle, the CPU runs again before the internal reset lands. During that window, writes to internal RAM are blocked.

A strap sequence on the address-latch and program-strobe pins during reset puts the chip into a float-all debug mode. In that mode the external test equipment drives the board and the CPU clock is held off.

Top module: `pmr_ctrl`

## Requirements
- R1: Internal reset rises only at the end of the second complete machine cycle (12 oscillator periods each, counted from the machine-cycle boundary) during which the reset pin was high on every clock. A pin pulse that drops earlier leaves it low. From the cycle the pin goes high, it takes between 24 and 35 clocks for internal reset to read high.
- R2: Internal reset falls on the clock after the reset pin is sampled low. After release the block is in run: CPU enable 1, peripheral enable 1, oscillator enable 1, RAM write block 0.
- R3: An idle request pulse in run gives, on the next cycle, CPU enable 0 with peripheral and oscillator enables still 1.
- R4: In idle, any set bit of the interrupt-pending vector returns the block to run on the next cycle. With the vector all zero, idle persists.
- R5: A power-down request pulse in run drives oscillator, CPU and peripheral enables to 0 on the next cycle. While in power-down, the oscillator enable follows the reset pin high with no clock delay.
- R6: In power-down, interrupt-pending bits, requests and reset pulses too short to qualify have no effect. Only internal reset leaves it, and run enables return on the cycle after internal reset rises.
- R7: When idle and power-down requests arrive in the same cycle, power-down is entered.
- R8: In idle, a high reset pin resumes the CPU on the next cycle with the RAM write block set. The block stays set until the cycle after internal reset rises, or until the pin drops first, which returns to plain run.
- R9: Debug-float mode sets when internal reset is released with the address-latch pin low at the release clock. On the last reset clock before release, the address-latch pin must also have been low and the program-strobe pin high. Otherwise it stays clear.
- R10: In debug-float mode the CPU enable is 0, the peripheral and oscillator enables are 1, and idle and power-down requests are ignored. A reset released with the address-latch pin high clears the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | External reset pin level, active high |
| idle_req | input | 1 | Single-cycle software request for idle |
| pd_req | input | 1 | Single-cycle software request for power-down |
| irq_pend | input | IRQ_W | Pending flags of enabled interrupts |
| ale_pin | input | 1 | Sampled address-latch pin level |
| psen_pin | input | 1 | Sampled program-strobe pin level |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| rst_int | output | 1 | Qualified internal reset |
| ram_wr_block | output | 1 | Inhibits internal RAM writes |
| dbg_float | output | 1 | Debug-float mode: port 0 floats, the other ports and strobes are weakly pulled high |

## Verification
Two collisions matter most, and the bench drives both.

- **Idle exit by interrupt versus reset pin.** The interrupt bit and the reset pin are raised in the same cycle while the block is idle. The reset pin must win, taking the block into the wake window with RAM writes blocked. The wake window is also closed both ways: by a qualified reset, and by a pin that drops before qualifying.
- **Idle versus power-down request.** Both request pulses are raised together. Power-down must win, which shows as both the peripheral and oscillator enables falling on the next cycle.

A behavioural reference model steps alongside the design on every clock and judges each of these outcomes.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_DOWN = 2'd2,
        MODE_WAKE = 2'd3
    } pmode_e;

    typedef struct packed {
        logic cpu_en;
        logic per_en;
        logic osc_en;
        logic ram_blk;
    } gate_t;

    // Clock and inhibit pattern implied by an operating state.
    function automatic gate_t gates_for(pmode_e m, logic dbg);
        gate_t g;
        g.cpu_en  = ((m == MODE_RUN) || (m == MODE_WAKE)) && !dbg;
        g.per_en  = (m != MODE_DOWN);
        g.osc_en  = (m != MODE_DOWN);
        g.ram_blk = (m == MODE_WAKE);
        return g;
    endfunction

endpackage

// File: rtl/pmr_mc_timer.sv
module pmr_mc_timer #(
    parameter int OSC_PER_MC = 12
) (
    input  logic osc_clk,
    input  logic hold,
    input  logic run,
    output logic mc_stb
);
    localparam int CW = (OSC_PER_MC > 2) ? $clog2(OSC_PER_MC) : 1;
    localparam logic [CW-1:0] LAST = CW'(OSC_PER_MC - 1);

    logic [CW-1:0] phase;

    // Phase is parked at zero while reset is held, frozen while the oscillator is off.
    always_ff @(posedge osc_clk) begin
        if (hold) begin
            phase <= '0;
        end else if (run) begin
            phase <= (phase >= LAST) ? '0 : phase + CW'(1);
        end
    end

    assign mc_stb = run && !hold && (phase == LAST);

endmodule

// File: rtl/pmr_rst_filter.sv
module pmr_rst_filter #(
    parameter int RST_MCS = 2
) (
    input  logic osc_clk,
    input  logic rst_pin,
    input  logic mc_stb,
    output logic rst_int
);
    localparam int FW = $clog2(RST_MCS + 1);
    localparam logic [FW-1:0] GOAL = FW'(RST_MCS - 1);
    localparam logic [FW-1:0] TOP  = FW'(RST_MCS);

    logic [FW-1:0] full_mcs;
    logic          clean;
    logic          rst_q;

    // clean: pin has been high on every clock of the current machine cycle.
    always_ff @(posedge osc_clk) begin
        if (mc_stb) begin
            clean <= 1'b1;
        end else if (!rst_pin) begin
            clean <= 1'b0;
        end
    end

    always_ff @(posedge osc_clk) begin
        if (!rst_pin) begin
            full_mcs <= '0;
            rst_q    <= 1'b0;
        end else if (mc_stb && clean) begin
            if (full_mcs == GOAL) begin
                rst_q <= 1'b1;
            end
            if (full_mcs != TOP) begin
                full_mcs <= full_mcs + FW'(1);
            end
        end
    end

    assign rst_int = rst_q;

endmodule

// File: rtl/pmr_mode_fsm.sv
module pmr_mode_fsm
    import pmr_pkg::*;
#(
    parameter int IRQ_W = 5
) (
    input  logic             osc_clk,
    input  logic             rst_int,
    input  logic             rst_pin,
    input  logic             idle_req,
    input  logic             pd_req,
    input  logic [IRQ_W-1:0] irq_pend,
    input  logic             ale_pin,
    input  logic             psen_pin,
    output pmode_e           mode,
    output logic             dbg
);
    logic   armed;
    pmode_e mode_nx;

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MODE_RUN: begin
                if (!dbg) begin
                    if (pd_req) begin
                        mode_nx = MODE_DOWN;
                    end else if (idle_req) begin
                        mode_nx = MODE_IDLE;
                    end
                end
            end
            MODE_IDLE: begin
                if (rst_pin) begin
                    mode_nx = MODE_WAKE;
                end else if (|irq_pend) begin
                    mode_nx = MODE_RUN;
                end
            end
            MODE_DOWN: mode_nx = MODE_DOWN;
            MODE_WAKE: begin
                if (!rst_pin) begin
                    mode_nx = MODE_RUN;
                end
            end
        endcase
    end

    // Internal reset acts as the synchronous reset of the state machine.
    always_ff @(posedge osc_clk) begin
        if (rst_int) begin
            mode  <= MODE_RUN;
            armed <= !ale_pin && psen_pin;
            dbg   <= rst_pin ? 1'b0 : (armed && !ale_pin);
        end else begin
            mode  <= mode_nx;
            armed <= 1'b0;
        end
    end

endmodule

// File: rtl/pmr_ctrl.sv
module pmr_ctrl
    import pmr_pkg::*;
#(
    parameter int OSC_PER_MC = 12,
    parameter int RST_MCS    = 2,
    parameter int IRQ_W      = 5
) (
    input  logic             osc_clk,
    input  logic             rst_pin,
    input  logic             idle_req,
    input  logic             pd_req,
    input  logic [IRQ_W-1:0] irq_pend,
    input  logic             ale_pin,
    input  logic             psen_pin,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_run,
    output logic             rst_int,
    output logic             ram_wr_block,
    output logic             dbg_float
);
    pmode_e mode;
    logic   dbg;
    logic   mc_stb;
    gate_t  g;

    assign g       = gates_for(mode, dbg);
    assign osc_run = g.osc_en || rst_pin;

    pmr_mc_timer #(.OSC_PER_MC(OSC_PER_MC)) u_timer (
        .osc_clk (osc_clk),
        .hold    (rst_int),
        .run     (osc_run),
        .mc_stb  (mc_stb)
    );

    pmr_rst_filter #(.RST_MCS(RST_MCS)) u_filter (
        .osc_clk (osc_clk),
        .rst_pin (rst_pin),
        .mc_stb  (mc_stb),
        .rst_int (rst_int)
    );

    pmr_mode_fsm #(.IRQ_W(IRQ_W)) u_fsm (
        .osc_clk  (osc_clk),
        .rst_int  (rst_int),
        .rst_pin  (rst_pin),
        .idle_req (idle_req),
        .pd_req   (pd_req),
        .irq_pend (irq_pend),
        .ale_pin  (ale_pin),
        .psen_pin (psen_pin),
        .mode     (mode),
        .dbg      (dbg)
    );

    assign cpu_clk_en   = g.cpu_en;
    assign per_clk_en   = g.per_en;
    assign ram_wr_block = g.ram_blk;
    assign dbg_float    = dbg;

endmodule

// File: rtl/pmr_ctrl_chk.sv
module pmr_ctrl_chk #(
    parameter int IRQ_W = 5
) (
    input logic             osc_clk,
    input logic             rst_pin,
    input logic             idle_req,
    input logic             pd_req,
    input logic [IRQ_W-1:0] irq_pend,
    input logic             ale_pin,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             osc_run,
    input logic             rst_int,
    input logic             ram_wr_block,
    input logic             dbg_float
);
    // Checks start once a first internal reset has defined every state register.
    logic live;
    initial live = 1'b0;
    always @(posedge osc_clk) begin
        if (rst_int) begin
            live <= 1'b1;
        end
    end

    a_r1_rise_needs_pin: assert property (@(posedge osc_clk) disable iff (!live)
        $rose(rst_int) |-> $past(rst_pin));

    a_r2_release: assert property (@(posedge osc_clk) disable iff (!live)
        !rst_pin |=> !rst_int);

    a_r3_idle_entry: assert property (@(posedge osc_clk) disable iff (!live)
        (idle_req && !pd_req && cpu_clk_en && !ram_wr_block && !rst_int)
        |=> (!cpu_clk_en && per_clk_en));

    a_r4_irq_wake: assert property (@(posedge osc_clk) disable iff (!live)
        (!cpu_clk_en && per_clk_en && !dbg_float && (|irq_pend) && !rst_pin && !rst_int)
        |=> (cpu_clk_en && !ram_wr_block));

    a_r5_down_osc: assert property (@(posedge osc_clk) disable iff (!live)
        (!per_clk_en && !rst_pin) |-> !osc_run);

    a_r6_down_sticky: assert property (@(posedge osc_clk) disable iff (!live)
        (!per_clk_en && !rst_int) |=> !per_clk_en);

    a_r7_down_wins: assert property (@(posedge osc_clk) disable iff (!live)
        (idle_req && pd_req && cpu_clk_en && !ram_wr_block && !rst_int && !dbg_float)
        |=> !per_clk_en);

    a_r8_block_runs_cpu: assert property (@(posedge osc_clk) disable iff (!live)
        ram_wr_block |-> cpu_clk_en);

    a_r9_float_entry: assert property (@(posedge osc_clk) disable iff (!live)
        $rose(dbg_float) |-> ($past(rst_int) && !$past(ale_pin)));

    a_r10_float_cpu_off: assert property (@(posedge osc_clk) disable iff (!live)
        dbg_float |-> (!cpu_clk_en && per_clk_en && osc_run));

endmodule

bind pmr_ctrl pmr_ctrl_chk #(.IRQ_W(IRQ_W)) u_chk (
    .osc_clk      (osc_clk),
    .rst_pin      (rst_pin),
    .idle_req     (idle_req),
    .pd_req       (pd_req),
    .irq_pend     (irq_pend),
    .ale_pin      (ale_pin),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .osc_run      (osc_run),
    .rst_int      (rst_int),
    .ram_wr_block (ram_wr_block),
    .dbg_float    (dbg_float)
);

// File: tb/pmr_ctrl_tb.sv
module pmr_ctrl_tb;
    localparam int MC    = 12;
    localparam int NEED  = 2;
    localparam int IRQ_W = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             pin = 1'b1, idle = 1'b0, pd = 1'b0, ale = 1'b1, psen = 1'b1;
    logic [IRQ_W-1:0] irq = '0;
    logic cpu_en, per_en, osc_en, rst_o, blk, dbgf;

    pmr_ctrl #(.OSC_PER_MC(MC), .RST_MCS(NEED), .IRQ_W(IRQ_W)) u_dut (
        .osc_clk(clk), .rst_pin(pin), .idle_req(idle), .pd_req(pd), .irq_pend(irq),
        .ale_pin(ale), .psen_pin(psen), .cpu_clk_en(cpu_en), .per_clk_en(per_en),
        .osc_run(osc_en), .rst_int(rst_o), .ram_wr_block(blk), .dbg_float(dbgf)
    );

    int  n_chk = 0, n_fail = 0, cycles = 0;
    bit  locked = 0, done = 0;

    task automatic check(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph = 0, m_full = 0, m_md = 0;   // md: 0 run, 1 idle, 2 down, 3 wake
    bit m_clean = 1, m_r = 1, m_dbg = 0, m_arm = 0;

    always @(posedge clk) begin
        if (locked) begin
            bit osc_on, strobe, n_clean, n_r, n_dbg, n_arm;
            int n_ph, n_full, n_md;
            osc_on = (m_md != 2) || pin;
            strobe = osc_on && !m_r && (m_ph == MC - 1);
            n_ph   = m_r ? 0 : (osc_on ? (m_ph + 1) % MC : m_ph);
            n_clean = strobe ? 1'b1 : (pin ? m_clean : 1'b0);
            n_full = m_full;
            n_r    = m_r;
            if (!pin) begin
                n_full = 0;
                n_r = 0;
            end else if (strobe && m_clean) begin
                if (m_full == NEED - 1) n_r = 1;
                n_full = m_full + 1;
            end
            n_md = m_md;
            n_dbg = m_dbg;
            n_arm = 0;
            if (m_r) begin
                n_md  = 0;
                n_arm = !ale && psen;
                n_dbg = pin ? 1'b0 : (m_arm && !ale);
            end else if (m_md == 0) begin
                if (!m_dbg && pd) n_md = 2;
                else if (!m_dbg && idle) n_md = 1;
            end else if (m_md == 1) begin
                if (pin) n_md = 3;
                else if (irq != 0) n_md = 0;
            end else if (m_md == 3) begin
                if (!pin) n_md = 0;
            end
            m_ph = n_ph; m_clean = n_clean; m_full = n_full; m_r = n_r;
            m_md = n_md; m_dbg = n_dbg; m_arm = n_arm;
        end
    end

    always @(negedge clk) begin
        #3;
        if (!locked) begin
            if (rst_o === 1'b1) begin
                locked = 1; m_ph = 0; m_clean = 1; m_full = NEED; m_r = 1;
                m_md = 0; m_dbg = 0; m_arm = 0;
            end
        end else begin
            check("R3", "model cpu_clk_en", cpu_en, (m_md == 0 || m_md == 3) && !m_dbg);
            check("R6", "model per_clk_en", per_en, m_md != 2);
            check("R5", "model osc_run", osc_en, (m_md != 2) || pin);
            check("R1", "model rst_int", rst_o, m_r);
            check("R8", "model ram_wr_block", blk, m_md == 3);
            check("R9", "model dbg_float", dbgf, m_dbg);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog expired: actual hung expected finished");
            report();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    // Raise the pin, wait for qualification, release with the given strap levels.
    task automatic do_reset(logic ale_hold, logic psen_hold, logic ale_rel);
        bit seen = 0;
        ale = ale_hold; psen = psen_hold; pin = 1'b1;
        for (int i = 0; i < 60; i++) begin
            step(1);
            if (rst_o) begin
                seen = 1;
                break;
            end
        end
        check("R1", "internal reset reached", seen, 1'b1);
        step(2);
        ale = ale_rel; pin = 1'b0;
        step(1);
        check("R2", "released rst_int", rst_o, 1'b0);
        ale = 1'b1; psen = 1'b1;
    endtask

    task automatic pulse_idle();
        idle = 1'b1; step(1); idle = 1'b0;
    endtask

    initial begin
        int n;
        // Power-up reset
        step(2);
        do_reset(1'b1, 1'b1, 1'b1);
        check("R2", "run cpu", cpu_en, 1'b1);
        check("R2", "run per", per_en, 1'b1);
        check("R2", "run osc", osc_en, 1'b1);
        check("R2", "run block", blk, 1'b0);
        check("R10", "no float after plain reset", dbgf, 1'b0);

        // R1: short pin pulse never qualifies
        step(3);
        pin = 1'b1;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (rst_o) n++;
        end
        pin = 1'b0;
        step(1);
        check("R1", "20-clock pulse no reset", n != 0, 1'b0);
        check("R1", "cpu unaffected by short pulse", cpu_en, 1'b1);

        // R1: qualification latency window
        step(5);
        pin = 1'b1;
        n = 0;
        for (int i = 0; i < 60; i++) begin
            step(1);
            n++;
            if (rst_o) break;
        end
        check("R1", "latency >= 24", n >= 24, 1'b1);
        check("R1", "latency <= 35", n <= 35, 1'b1);
        step(1);
        pin = 1'b0;
        step(1);
        check("R2", "release after latency test", rst_o, 1'b0);

        // R3 / R4: idle entry and interrupt exit
        step(2);
        pulse_idle();
        check("R3", "idle cpu off", cpu_en, 1'b0);
        check("R3", "idle per on", per_en, 1'b1);
        check("R3", "idle osc on", osc_en, 1'b1);
        step(8);
        check("R4", "idle persists without irq", cpu_en, 1'b0);
        irq = 5'b01000; step(1); irq = '0;
        check("R4", "irq wakes cpu", cpu_en, 1'b1);
        check("R4", "irq wake no block", blk, 1'b0);

        // R5 / R6: power-down
        step(2);
        pd = 1'b1; step(1); pd = 1'b0;
        check("R5", "down osc off", osc_en, 1'b0);
        check("R5", "down cpu off", cpu_en, 1'b0);
        check("R5", "down per off", per_en, 1'b0);
        irq = 5'b11111; idle = 1'b1; step(1); irq = '0; idle = 1'b0;
        step(1);
        check("R6", "irq ignored in down", per_en, 1'b0);
        pin = 1'b1; #1;
        check("R5", "pin restarts osc", osc_en, 1'b1);
        step(5);
        pin = 1'b0; step(1);
        check("R6", "short pulse keeps down", osc_en, 1'b0);
        check("R6", "short pulse keeps per off", per_en, 1'b0);
        step(3);
        do_reset(1'b1, 1'b1, 1'b1);
        check("R6", "reset leaves down", per_en, 1'b1);
        check("R6", "reset leaves down cpu", cpu_en, 1'b1);

        // R7: simultaneous requests
        step(2);
        idle = 1'b1; pd = 1'b1; step(1); idle = 1'b0; pd = 1'b0;
        check("R7", "down wins per", per_en, 1'b0);
        check("R7", "down wins osc", osc_en, 1'b0);
        do_reset(1'b1, 1'b1, 1'b1);

        // R8: reset pin ends idle, reaches internal reset; irq collides with the pin
        step(2);
        pulse_idle();
        pin = 1'b1; irq = 5'b00001; step(1); irq = '0;
        check("R8", "wake cpu on", cpu_en, 1'b1);
        check("R8", "wake block on", blk, 1'b1);
        n = 0;
        for (int i = 0; i < 60; i++) begin
            step(1);
            if (rst_o) begin
                n = 1;
                break;
            end
        end
        check("R8", "wake window reaches reset", n, 1);
        step(1);
        check("R8", "block cleared after reset", blk, 1'b0);
        pin = 1'b0; step(1);

        // R8: pin drops before qualifying
        step(2);
        pulse_idle();
        pin = 1'b1; step(3);
        check("R8", "short wake block", blk, 1'b1);
        pin = 1'b0; step(1);
        check("R8", "pin drop clears block", blk, 1'b0);
        check("R8", "pin drop cpu runs", cpu_en, 1'b1);

        // R9 negatives
        step(2);
        do_reset(1'b0, 1'b0, 1'b0);
        check("R9", "strobe low no float", dbgf, 1'b0);
        do_reset(1'b0, 1'b1, 1'b1);
        check("R9", "latch pin high at release no float", dbgf, 1'b0);

        // R9 / R10: enter and exercise debug-float
        do_reset(1'b0, 1'b1, 1'b0);
        check("R9", "float entered", dbgf, 1'b1);
        check("R10", "float cpu off", cpu_en, 1'b0);
        idle = 1'b1; pd = 1'b1; step(1); idle = 1'b0; pd = 1'b0;
        check("R10", "float ignores requests per", per_en, 1'b1);
        check("R10", "float ignores requests osc", osc_en, 1'b1);
        check("R10", "float held", dbgf, 1'b1);
        do_reset(1'b1, 1'b1, 1'b1);
        check("R10", "normal reset clears float", dbgf, 1'b0);
        check("R10", "cpu back after float", cpu_en, 1'b1);

        step(4);
        report();
    end

endmodule